// File: doc/BRIEF.md
# Three-Axis Servo Register Block

This block sits between a processor's 32-bit data bus and the drive and feedback signals of three servo axes. For each axis it holds a signed drive command, captures a signed position sample from the axis sensor input, and keeps a set of sticky fault flags. While any fault flag of an axis is set, that axis's drive output is held at zero, whatever the stored command is.

Every register is reached with one plain read or write cycle. The map is flat and regular: each axis has its own 16-byte slot, and there are no page registers and no access sequences. The drive command reads back what software last wrote, so driver code needs no shadow copies. Signed values read back sign-extended to 32 bits. Fault flags are cleared by writing ones to them, and unmapped reads return zero.

Top module: `servo_axis_regs`

## Requirements
- R1: A synchronous active-high `rst` clears every drive command, position sample, fault flag and `bus_rdata` to zero, so `drive_out` is all zero after reset.
- R2: Axis N (0 to 2) is based at byte address N*0x10. Word offset 0x0 is the drive command, 0x4 the position sample and 0x8 the fault flags. Address bits [1:0] are ignored.
- R3: A write to a drive command stores `bus_wdata[9:0]` and ignores the upper bits. A read returns the value sign-extended from bit 9 to 32 bits.
- R4: Each axis's position sample loads its 8-bit slice of `pos_in` on every clock edge outside reset. A read returns it sign-extended from bit 7. Writes to the position offset have no effect.
- R5: A fault input bit that is high at a clock edge sets the matching fault flag at that edge. The flag stays set after the input falls.
- R6: A write to the fault offset clears each flag whose bit in `bus_wdata[2:0]` is 1 and leaves the others unchanged. A fault input that is high in the same cycle keeps its flag set. Fault reads return zero in bits [31:3].
- R7: Each axis's 10-bit slice of `drive_out` equals its drive command while all of its fault flags are clear, and is zero while any of them is set.
- R8: A read of an unmapped address (slot 3 and above, or word offset 0xC) returns zero. A write to an unmapped address changes no register.
- R9: `bus_rdata` loads at a clock edge where `bus_rd` is high, with the register contents from before that edge's write. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pos_in | input | 24 | Position feedback, axis N in bits [8N+7:8N] |
| fault_in | input | 9 | Fault inputs, axis N in bits [3N+2:3N] |
| drive_out | output | 30 | Gated drive commands, axis N in bits [10N+9:10N] |

## Verification
The bench aims at the fault interplay. It uses a single-cycle fault pulse, which a non-sticky flag would lose, letting the drive return. It writes a clear with the wrong bit set, which an over-eager clear would wipe. It raises a fault in the same cycle as its clear, which a clear-wins priority would drop. It also writes drive values with junk in the upper bits and uses both signs at the 10-bit and 8-bit extremes, where missing sign extension or masking shows up directly in the read data. Further cases are reads at unmapped slots and at offset 0xC, a write to the position offset, a misaligned address, and a read and write in the same cycle, which a design that forwards the new data would get wrong.

// File: rtl/servo_axis_regs.sv
module servo_axis_regs #(
  parameter int NAXES = 3,
  parameter int DRV_W = 10,
  parameter int POS_W = 8,
  parameter int ERR_W = 3,
  parameter int AW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NAXES*POS_W-1:0] pos_in,
  input  logic [NAXES*ERR_W-1:0] fault_in,
  output logic [NAXES*DRV_W-1:0] drive_out
);
  localparam int SLOT_W = AW - 4;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        word;
  logic              mapped;
  logic [31:0]       rd_val;

  logic [DRV_W-1:0] drv_q [NAXES];
  logic [POS_W-1:0] pos_q [NAXES];
  logic [ERR_W-1:0] err_q [NAXES];

  assign slot   = bus_addr[AW-1:4];
  assign word   = bus_addr[3:2];
  assign mapped = (32'(slot) < NAXES) && (word != 2'd3);

  for (genvar g = 0; g < NAXES; g++) begin : g_axis
    logic             hit;
    logic [ERR_W-1:0] clr;

    assign hit = (slot == SLOT_W'(g));
    assign clr = (bus_wr && hit && word == 2'd2) ? bus_wdata[ERR_W-1:0] : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        drv_q[g] <= '0;
        pos_q[g] <= '0;
        err_q[g] <= '0;
      end else begin
        if (bus_wr && hit && word == 2'd0) drv_q[g] <= bus_wdata[DRV_W-1:0];
        pos_q[g] <= pos_in[g*POS_W +: POS_W];
        err_q[g] <= (err_q[g] & ~clr) | fault_in[g*ERR_W +: ERR_W];
      end
    end

    assign drive_out[g*DRV_W +: DRV_W] = (|err_q[g]) ? '0 : drv_q[g];

    p_fault_kills_drive_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(|fault_in[g*ERR_W +: ERR_W])) |-> drive_out[g*DRV_W +: DRV_W] == '0);

    p_fault_latched_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(|fault_in[g*ERR_W +: ERR_W])) |-> (|err_q[g]));
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NAXES; i++) begin
      if (slot == SLOT_W'(i)) begin
        case (word)
          2'd0:    rd_val = {{(32-DRV_W){drv_q[i][DRV_W-1]}}, drv_q[i]};
          2'd1:    rd_val = {{(32-POS_W){pos_q[i][POS_W-1]}}, pos_q[i]};
          2'd2:    rd_val = {{(32-ERR_W){1'b0}}, err_q[i]};
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == '0 && drive_out == '0));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd) && !$past(mapped)) |-> bus_rdata == '0);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_rd)) |-> $stable(bus_rdata));
endmodule

// File: tb/servo_axis_regs_tb.sv
module servo_axis_regs_tb;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [23:0] pos_in = 0;
  logic [8:0]  fault_in = 0;
  logic [29:0] drive_out;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [9:0]  m_drv [3];
  logic [7:0]  m_pos [3];
  logic [2:0]  m_err [3];
  logic [31:0] m_rd;

  servo_axis_regs u_dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pos_in(pos_in),
    .fault_in(fault_in), .drive_out(drive_out));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    int ax = int'(a[7:4]);
    if (ax > 2) return 0;
    case (a[3:2])
      2'd0: return {{22{m_drv[ax][9]}}, m_drv[ax]};
      2'd1: return {{24{m_pos[ax][7]}}, m_pos[ax]};
      2'd2: return {29'd0, m_err[ax]};
      default: return 0;
    endcase
  endfunction

  task automatic tick(input string tag);
    @(posedge clk); #1;
    if (rst) begin
      m_rd = 0;
      for (int i = 0; i < 3; i++) begin m_drv[i] = 0; m_pos[i] = 0; m_err[i] = 0; end
    end else begin
      if (bus_rd) m_rd = mread(bus_addr);
      for (int i = 0; i < 3; i++) begin
        logic [2:0] clr;
        clr = (bus_wr && int'(bus_addr[7:4]) == i && bus_addr[3:2] == 2'd2) ? bus_wdata[2:0] : 3'd0;
        m_err[i] = (m_err[i] & ~clr) | fault_in[i*3 +: 3];
        m_pos[i] = pos_in[i*8 +: 8];
        if (bus_wr && int'(bus_addr[7:4]) == i && bus_addr[3:2] == 2'd0) m_drv[i] = bus_wdata[9:0];
      end
    end
    chk(bus_rdata === m_rd, tag, bus_rdata, m_rd);
    for (int i = 0; i < 3; i++) begin
      logic [9:0] e;
      e = (|m_err[i]) ? 10'd0 : m_drv[i];
      chk(drive_out[i*10 +: 10] === e, "R7 drive gating", 32'(drive_out[i*10 +: 10]), 32'(e));
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick(tag);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_rd = 1; bus_addr = a;
    tick(tag);
    bus_rd = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    tick("R1 reset"); tick("R1 reset");
    rst = 0;
    tick("R1 after reset");
    chk(bus_rdata == 0 && drive_out == 0, "R1 reset state", {2'b0, drive_out}, 0);

    wr(8'h00, 32'h0000_01FF, "R3 write ax0");
    wr(8'h10, 32'hFFFF_FFFD, "R3 write ax1");
    wr(8'h20, 32'hABCD_E200, "R3 write ax2 junk upper");
    rd(8'h00, "R3 read ax0");
    chk(bus_rdata == 32'h0000_01FF, "R3 ax0 positive", bus_rdata, 32'h0000_01FF);
    rd(8'h10, "R3 read ax1");
    rd(8'h20, "R3 read ax2");
    chk(bus_rdata == 32'hFFFF_FE00, "R3 ax2 sign ext", bus_rdata, 32'hFFFF_FE00);
    chk(drive_out[29:20] == 10'h200, "R7 ax2 drive", 32'(drive_out[29:20]), 32'h200);

    pos_in = {8'h05, 8'h80, 8'h7F};
    tick("R4 capture");
    rd(8'h04, "R4 pos ax0");
    chk(bus_rdata == 32'h0000_007F, "R4 pos ax0", bus_rdata, 32'h7F);
    rd(8'h14, "R4 pos ax1");
    chk(bus_rdata == 32'hFFFF_FF80, "R4 pos ax1 sign", bus_rdata, 32'hFFFF_FF80);
    wr(8'h24, 32'hFFFF_FFFF, "R4 pos write ignored");
    rd(8'h24, "R4 pos ax2 after write");
    chk(bus_rdata == 32'h0000_0005, "R4 write ignored", bus_rdata, 32'h5);

    fault_in = 9'b000_010_000;
    tick("R5 fault pulse");
    fault_in = 0;
    tick("R5 fault sticky");
    chk(drive_out[19:10] == 0, "R7 ax1 forced off", 32'(drive_out[19:10]), 0);
    rd(8'h18, "R5 read err ax1");
    chk(bus_rdata == 32'h2, "R5 flag stays", bus_rdata, 32'h2);
    wr(8'h18, 32'hFFFF_FFF9, "R6 clear wrong bits");
    rd(8'h18, "R6 read after wrong clear");
    chk(bus_rdata == 32'h2, "R6 other bits kept", bus_rdata, 32'h2);
    fault_in = 9'b000_010_000;
    wr(8'h18, 32'h2, "R6 set wins over clear");
    fault_in = 0;
    rd(8'h18, "R6 read after collide");
    chk(bus_rdata == 32'h2, "R6 set wins", bus_rdata, 32'h2);
    wr(8'h18, 32'h2, "R6 clear");
    rd(8'h18, "R6 read cleared");
    chk(bus_rdata == 32'h0 && drive_out[19:10] == 10'h3FD, "R6 cleared, R7 drive back", bus_rdata, 0);

    fault_in = 9'b101_000_000;
    tick("R5 ax2 multi fault");
    fault_in = 0;
    rd(8'h28, "R6 err upper bits zero");
    chk(bus_rdata == 32'h5, "R6 err readback", bus_rdata, 32'h5);

    wr(8'h0C, 32'hFFFF_FFFF, "R8 write unmapped offset");
    wr(8'h30, 32'hFFFF_FFFF, "R8 write unmapped slot");
    rd(8'h0C, "R8 read offset C");
    chk(bus_rdata == 0, "R8 offset C zero", bus_rdata, 0);
    rd(8'h30, "R8 read slot 3");
    rd(8'hF0, "R8 read high slot");
    rd(8'h00, "R8 ax0 unchanged");
    chk(bus_rdata == 32'h0000_01FF, "R8 ax0 intact", bus_rdata, 32'h1FF);

    rd(8'h13, "R2 low addr bits ignored");
    chk(bus_rdata == 32'hFFFF_FFFD, "R2 misaligned read", bus_rdata, 32'hFFFF_FFFD);

    bus_rd = 1; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h0000_0155;
    tick("R9 read+write same cycle");
    bus_rd = 0; bus_wr = 0;
    chk(bus_rdata == 32'h0000_01FF, "R9 old value returned", bus_rdata, 32'h1FF);
    bus_addr = 8'h10;
    tick("R9 hold"); tick("R9 hold");
    chk(bus_rdata == 32'h0000_01FF, "R9 rdata holds", bus_rdata, 32'h1FF);

    rst = 1;
    tick("R1 reset again");
    rst = 0;
    rd(8'h28, "R1 err cleared by reset");
    chk(bus_rdata == 0 && drive_out == 0, "R1 second reset", {2'b0, drive_out}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule